// File: doc/BRIEF.md
# Multichannel Boxcar Averaging Decimator

This block reduces the rate of a stream of simultaneously captured signed samples by averaging them. Every input frame carries one 18-bit two's complement word for each of eight channels plus a valid strobe. The block adds up a run of consecutive valid frames for each channel in parallel. After the run length has been collected, it presents one averaged word per channel and raises a single-cycle done pulse. The filter is a first-order sinc: every sample in a run carries the same weight.

A 3-bit ratio code selects the run length. A code of zero, and also the all-ones code, passes each frame through unchanged. Codes one to six average 2, 4, 8, 16, 32 or 64 frames. The code is captured when a run begins, so the selection cannot change partway through a run. Longer runs trade output rate for lower noise. Every channel finishes on the same frame, so the outputs of one result frame always come from the same sampling instants.

Top module: `boxcar_decimator`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and on the cycle after it is released, `avg_done` and `busy` are low and every word of `avg_data` is zero.
- R2: With ratio code 000, each valid frame produces `avg_done` high on the following cycle, and each output word then equals the input word of its channel.
- R3: With ratio code n (1 to 6), `avg_done` rises on the cycle after the 2^n-th valid frame of a run. Each output word then equals the sum of those 2^n samples of its channel, arithmetically shifted right by n.
- R4: The shift truncates toward minus infinity, so a sum of -1 over two samples gives -1. Runs of 64 full-scale positive or full-scale negative samples give the full-scale value without overflow.
- R5: Ratio code 111 behaves exactly like code 000.
- R6: The ratio code is taken on the cycle of the first valid frame of a run. A different code applied later in that run takes effect only from the next run.
- R7: `busy` is high from the cycle after the first frame of a multi-frame run is accepted, up to and including the cycle before `avg_done`. It is low on the done cycle, and it is never high when the ratio is 1.
- R8: Frames with `smp_valid` low are ignored. They do not advance the run and do not change the sums.
- R9: Channel k occupies bits [18k+17:18k] of both `smp_data` and `avg_data`, and the channels are averaged independently of one another.
- R10: `avg_data` changes only on cycles where `avg_done` is high, and holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 3 | Averaging ratio select: 2^code for codes 1 to 6, 1 for codes 0 and 7 |
| smp_valid | input | 1 | Input frame strobe |
| smp_data | input | 144 | Eight packed signed 18-bit input samples |
| avg_data | output | 144 | Eight packed signed 18-bit averaged results |
| avg_done | output | 1 | One-cycle pulse when a result frame is ready |
| busy | output | 1 | A multi-frame run is in progress |

## Verification
The embedded properties check on every cycle that a done pulse only follows a valid frame and never coincides with `busy`. They also check that the run counter stays within 64, that the latched ratio is stable for the length of a run, that an idle accumulator is empty, that each shifted sum fits the output word, and that the outputs change only with done. The arithmetic itself, meaning the correct floor average per channel for every ratio, is shown only by the bench. It compares against a behavioural model on every clock. Its scenarios cover gapped valid strobes, the code 111 alias, a code change in the middle of a run, full-scale runs of both signs, and truncation of negative sums.

// File: rtl/osf_pkg.sv
package osf_pkg;
    // Ratio code width; the all-ones code is an alias of "no averaging".
    parameter int unsigned CODE_W    = 3;
    parameter int unsigned MAX_SHIFT = (1 << CODE_W) - 2;
    parameter int unsigned SH_W      = $clog2(MAX_SHIFT + 1);
    parameter int unsigned CNT_W     = MAX_SHIFT + 1;

    typedef struct packed {
        logic            first;  // no run in progress: this frame opens one
        logic            last;   // this valid frame closes the run
        logic [SH_W-1:0] shift;  // log2 of the ratio that governs this frame
    } burst_ctl_t;

    function automatic logic [SH_W-1:0] decode_shift(input logic [CODE_W-1:0] code);
        return (code == '1) ? '0 : SH_W'(code);
    endfunction
endpackage

// File: rtl/osf_burst_ctrl.sv
module osf_burst_ctrl
    import osf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] ratio_code,
    output burst_ctl_t        ctl,
    output logic              busy,
    output logic              done
);
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  shift_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_next;
    logic [SH_W-1:0]  shift_now;

    always_comb begin
        shift_now = active_q ? shift_q : decode_shift(ratio_code);
        cnt_next  = active_q ? cnt_q + CNT_W'(1) : CNT_W'(1);
        ctl.first = !active_q;
        ctl.shift = shift_now;
        ctl.last  = smp_valid && (cnt_next == (CNT_W'(1) << shift_now));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= ctl.last;
            if (smp_valid) begin
                if (ctl.last) begin
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                end else begin
                    active_q <= 1'b1;
                    cnt_q    <= cnt_next;
                    shift_q  <= shift_now;
                end
            end
        end
    end

    assign busy = active_q;
    assign done = done_q;

    // R3: a run never collects more than the largest ratio
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(1 << MAX_SHIFT));
    // R6: the ratio latched for a run holds until the run ends
    p_ratio_held_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(shift_q));
    // R7: busy is dropped on the cycle the result is announced
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

// File: rtl/osf_chan_acc.sv
module osf_chan_acc
    import osf_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned ACC_W  = DATA_W + MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  burst_ctl_t        ctl,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] avg
);
    localparam int unsigned EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  sum_next;
    logic signed [ACC_W-1:0]  shifted;
    logic        [DATA_W-1:0] avg_q;

    always_comb begin
        sum_next = (ctl.first ? '0 : acc_q)
                 + $signed({{EXT_W{sample[DATA_W-1]}}, sample});
        shifted  = sum_next >>> ctl.shift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            avg_q <= '0;
        end else if (smp_valid) begin
            if (ctl.last) begin
                acc_q <= '0;
                avg_q <= shifted[DATA_W-1:0];
            end else begin
                acc_q <= sum_next;
            end
        end
    end

    assign avg = avg_q;

    // R3: an accumulator outside a run holds nothing
    p_idle_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.first |-> (acc_q == '0));
    // R4: the scaled sum always fits the output word
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && ctl.last) |->
            ((shifted[ACC_W-1:DATA_W-1] == '0) || (shifted[ACC_W-1:DATA_W-1] == '1)));
endmodule

// File: rtl/boxcar_decimator.sv
module boxcar_decimator
    import osf_pkg::*;
#(
    parameter int unsigned N_CH   = 8,
    parameter int unsigned DATA_W = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CODE_W-1:0]        ratio_code,
    input  logic                     smp_valid,
    input  logic [N_CH*DATA_W-1:0]   smp_data,
    output logic [N_CH*DATA_W-1:0]   avg_data,
    output logic                     avg_done,
    output logic                     busy
);
    localparam int unsigned ACC_W = DATA_W + MAX_SHIFT;

    burst_ctl_t ctl;

    osf_burst_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .ratio_code (ratio_code),
        .ctl        (ctl),
        .busy       (busy),
        .done       (avg_done)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        osf_chan_acc #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_acc (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid),
            .ctl       (ctl),
            .sample    (smp_data[ch*DATA_W +: DATA_W]),
            .avg       (avg_data[ch*DATA_W +: DATA_W])
        );
    end

    // R3: a result frame only ever follows an accepted input frame
    p_done_follows_valid_r3: assert property (@(posedge clk) disable iff (rst)
        avg_done |-> $past(smp_valid));
    // R10: outputs move only together with the done pulse
    p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
        !avg_done |-> $stable(avg_data));
endmodule

// File: tb/tb_boxcar_decimator.sv
module tb_boxcar_decimator;
    localparam int N_CH   = 8;
    localparam int DATA_W = 18;
    localparam longint FS_POS = 131071;
    localparam longint FS_NEG = -131072;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [2:0]             ratio_code = '0;
    logic                   smp_valid = 1'b0;
    logic [N_CH*DATA_W-1:0] smp_data = '0;
    logic [N_CH*DATA_W-1:0] avg_data;
    logic                   avg_done;
    logic                   busy;

    boxcar_decimator #(.N_CH(N_CH), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .ratio_code(ratio_code), .smp_valid(smp_valid),
        .smp_data(smp_data), .avg_data(avg_data), .avg_done(avg_done), .busy(busy)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    longint cur[N_CH];
    longint sums[N_CH];
    longint exp_out[N_CH];
    int     m_cnt = 0;
    int     m_shift = 0;
    bit     m_active = 0;
    bit     exp_done = 0;
    bit     exp_busy = 0;

    task automatic check(string tag, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "avg_done", longint'(avg_done), longint'(exp_done));
        check(tag, "busy", longint'(busy), longint'(exp_busy));
        for (int k = 0; k < N_CH; k++)
            check(tag, $sformatf("avg_data ch%0d", k),
                  longint'($signed(avg_data[k*DATA_W +: DATA_W])), exp_out[k]);
    endtask

    task automatic model_reset();
        for (int k = 0; k < N_CH; k++) begin
            sums[k] = 0;
            exp_out[k] = 0;
        end
        m_cnt = 0; m_shift = 0; m_active = 0; exp_done = 0; exp_busy = 0;
    endtask

    // Called at a negedge: drives one frame, advances the model, compares after the edge.
    task automatic step(bit v, logic [2:0] code, string tag);
        smp_valid  = v;
        ratio_code = code;
        for (int k = 0; k < N_CH; k++)
            smp_data[k*DATA_W +: DATA_W] = cur[k][DATA_W-1:0];
        exp_done = 0;
        if (v) begin
            if (!m_active) begin
                m_shift = (code == 3'b111) ? 0 : int'(code);
                m_cnt = 0;
                for (int k = 0; k < N_CH; k++) sums[k] = 0;
            end
            for (int k = 0; k < N_CH; k++) sums[k] += cur[k];
            m_cnt++;
            if (m_cnt == (1 << m_shift)) begin
                for (int k = 0; k < N_CH; k++) exp_out[k] = sums[k] >>> m_shift;
                exp_done = 1;
                m_active = 0;
            end else begin
                m_active = 1;
            end
        end
        exp_busy = m_active;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        model_reset();
        @(negedge clk);
        compare("R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare("R1");
    endtask

    task automatic rand_frame();
        for (int k = 0; k < N_CH; k++)
            cur[k] = longint'($signed(18'($urandom)));
    endtask

    task automatic set_all(longint val);
        for (int k = 0; k < N_CH; k++) cur[k] = val;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_all(0);
        @(negedge clk);
        do_reset();

        // R2: pass-through, back-to-back and gapped
        for (int i = 0; i < 6; i++) begin
            rand_frame();
            step(1'b1, 3'b000, "R2");
            if (i % 2 == 1) step(1'b0, 3'b000, "R2");
        end

        // R3/R9: every ratio with random channel data, R8: gaps with junk data
        for (int n = 1; n <= 6; n++) begin
            for (int i = 0; i < (1 << n); i++) begin
                rand_frame();
                step(1'b1, 3'(n), "R3");
                if (i % 3 == 0) begin
                    rand_frame();
                    step(1'b0, 3'(n), "R8");
                end
            end
            step(1'b0, 3'(n), "R10");
            step(1'b0, 3'(n), "R10");
        end

        // R9: distinct per-channel constants over a ratio of 4
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < N_CH; k++) cur[k] = longint'(k * 1000 - 3000 + i);
            step(1'b1, 3'b010, "R9");
        end

        // R5: code 111 passes through like 000
        for (int i = 0; i < 4; i++) begin
            rand_frame();
            step(1'b1, 3'b111, "R5");
        end

        // R6: code changes during a run of 4 take effect afterwards
        rand_frame();
        step(1'b1, 3'b010, "R6");
        for (int i = 0; i < 3; i++) begin
            rand_frame();
            step(1'b1, (i == 0) ? 3'b000 : 3'b110, "R6");
        end
        rand_frame();
        step(1'b1, 3'b000, "R6");

        // R4: full scale both signs over 64, and negative truncation
        set_all(FS_POS);
        for (int i = 0; i < 64; i++) step(1'b1, 3'b110, "R4");
        set_all(FS_NEG);
        for (int i = 0; i < 64; i++) step(1'b1, 3'b110, "R4");
        set_all(-1);
        step(1'b1, 3'b001, "R4");
        set_all(0);
        step(1'b1, 3'b001, "R4");
        set_all(-3);
        step(1'b1, 3'b010, "R4");
        set_all(0);
        for (int i = 0; i < 3; i++) step(1'b1, 3'b010, "R4");

        // R7: busy across a run of 8 with gaps
        for (int i = 0; i < 8; i++) begin
            rand_frame();
            step(1'b1, 3'b011, "R7");
            step(1'b0, 3'b011, "R7");
        end

        // R1: reset in the middle of a run clears everything
        rand_frame();
        step(1'b1, 3'b100, "R1");
        step(1'b1, 3'b100, "R1");
        do_reset();
        rand_frame();
        step(1'b1, 3'b000, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule